// File: doc/BRIEF.md
# Four-Lane Permutation Interconnect

This block moves 16-bit words between four processing lanes of a data-parallel array. Each lane drives the value of its outgoing network register onto one input of the block. When an interconnect operation is issued, a valid strobe comes with a 4-bit function code. Each destination lane then takes the word from the source lane that the selected fixed permutation assigns to it. The result is stored in that lane's incoming network register.

Five permutations are defined:

- a rotation by one lane
- a full mirror of lane order
- an exchange of the two inner lanes
- an exchange within neighbouring pairs
- an exchange of the two halves

All routes are fixed in advance, so the block has no arbitration and no routing state. A function code outside the defined set is refused. The stored words stay as they are, and a one-cycle flag reports the refusal.

Top module: `lane_permute_net`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four lane outputs become 0 and `bad_fn_o` becomes 0.
- R2: Function code 4'b0000 (rotate) stores lane 0 into output 1, lane 1 into output 2, lane 2 into output 3, and lane 3 into output 0.
- R3: Function code 4'b0001 (mirror) stores lane 3 into output 0, lane 2 into output 1, lane 1 into output 2, and lane 0 into output 3.
- R4: Function code 4'b0010 (inner swap) stores lane 2 into output 1 and lane 1 into output 2. Outputs 0 and 3 take lanes 0 and 3 unchanged.
- R5: Function code 4'b0011 (pair swap) exchanges lanes 0 and 1, and exchanges lanes 2 and 3.
- R6: Function code 4'b0100 (half swap) exchanges lanes 0 and 2, and exchanges lanes 1 and 3.
- R7: Outputs take a new value at the first rising edge at which `net_valid_i` is high. Before that edge they still show the earlier value.
- R8: At an edge where `net_valid_i` is low, all lane outputs keep their value, whatever the lane inputs and function code are.
- R9: At an edge where `net_valid_i` is high and the function code is 4'b0101 through 4'b1111, the lane outputs keep their value and `bad_fn_o` is 1 for the following cycle.
- R10: `bad_fn_o` is 0 after every edge that did not see a valid strobe carrying an illegal code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| net_valid_i | input | 1 | Strobe: perform the exchange at this edge |
| net_fn_i | input | 4 | Permutation function code |
| lane0_i | input | 16 | Outgoing network word of lane 0 |
| lane1_i | input | 16 | Outgoing network word of lane 1 |
| lane2_i | input | 16 | Outgoing network word of lane 2 |
| lane3_i | input | 16 | Outgoing network word of lane 3 |
| lane0_o | output | 16 | Incoming network register of lane 0 |
| lane1_o | output | 16 | Incoming network register of lane 1 |
| lane2_o | output | 16 | Incoming network register of lane 2 |
| lane3_o | output | 16 | Incoming network register of lane 3 |
| bad_fn_o | output | 1 | One-cycle flag for a refused function code |

## Verification
The case that is hardest to show from the ports is that a refused code leaves the stored words untouched. A hold is only visible when the registers already contain distinct data and the inputs present different data at the refused edge. The stimulus therefore first loads distinct words with a legal permutation. It then sends all eleven illegal codes with fresh, distinct lane inputs. After each one it checks that the outputs still equal the earlier result, that the flag was raised for that cycle, and that the flag has dropped one cycle later.

// File: rtl/pnet_pkg.sv
package pnet_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned WIDTH  = 16;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned SEL_W  = $clog2(LANES);
    localparam int unsigned HALF   = LANES / 2;

    typedef enum logic [CODE_W-1:0] {
        FN_ROTATE = 4'd0,
        FN_MIRROR = 4'd1,
        FN_INNER  = 4'd2,
        FN_PAIR   = 4'd3,
        FN_HALF   = 4'd4
    } pnet_fn_e;

    localparam logic [CODE_W-1:0] FN_LAST = FN_HALF;

    typedef logic [WIDTH-1:0] word_t;
    typedef logic [SEL_W-1:0] lane_sel_t;
    typedef word_t [LANES-1:0] lane_vec_t;

    typedef struct packed {
        logic                      legal;
        lane_sel_t [LANES-1:0]     src;
    } route_t;

    // Source lane feeding destination lane dst for a given function.
    function automatic lane_sel_t src_lane(logic [CODE_W-1:0] fn, int unsigned dst);
        int unsigned s;
        case (fn)
            FN_ROTATE: s = (dst + LANES - 1) % LANES;
            FN_MIRROR: s = LANES - 1 - dst;
            FN_INNER:  begin
                if (dst == HALF - 1)  s = HALF;
                else if (dst == HALF) s = HALF - 1;
                else                  s = dst;
            end
            FN_PAIR:   s = dst ^ 1;
            FN_HALF:   s = (dst + HALF) % LANES;
            default:   s = dst;
        endcase
        return lane_sel_t'(s);
    endfunction

    function automatic logic fn_is_legal(logic [CODE_W-1:0] fn);
        return fn <= FN_LAST;
    endfunction

endpackage

// File: rtl/pnet_decode.sv
module pnet_decode
    import pnet_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output route_t            route_o
);
    always_comb begin
        route_o.legal = fn_is_legal(code_i);
        for (int unsigned d = 0; d < LANES; d++) begin
            route_o.src[d] = src_lane(code_i, d);
        end
    end
endmodule

// File: rtl/pnet_mux.sv
module pnet_mux
    import pnet_pkg::*;
(
    input  lane_vec_t data_i,
    input  route_t    route_i,
    output lane_vec_t data_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb data_o[g] = data_i[route_i.src[g]];
    end
endmodule

// File: rtl/pnet_capture.sv
module pnet_capture
    import pnet_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid_i,
    input  logic      legal_i,
    input  lane_vec_t data_i,
    output lane_vec_t data_o,
    output logic      bad_o
);
    lane_vec_t data_q;
    logic      bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            if (valid_i && legal_i) data_q <= data_i;
            bad_q <= valid_i && !legal_i;
        end
    end

    assign data_o = data_q;
    assign bad_o  = bad_q;
endmodule

// File: rtl/lane_permute_net.sv
module lane_permute_net
    import pnet_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        net_valid_i,
    input  logic [3:0]  net_fn_i,
    input  logic [15:0] lane0_i,
    input  logic [15:0] lane1_i,
    input  logic [15:0] lane2_i,
    input  logic [15:0] lane3_i,
    output logic [15:0] lane0_o,
    output logic [15:0] lane1_o,
    output logic [15:0] lane2_o,
    output logic [15:0] lane3_o,
    output logic        bad_fn_o
);
    lane_vec_t in_vec, routed_vec, out_vec;
    route_t    route;

    assign in_vec = {lane3_i, lane2_i, lane1_i, lane0_i};

    pnet_decode i_decode (
        .code_i  (net_fn_i),
        .route_o (route)
    );

    pnet_mux i_mux (
        .data_i  (in_vec),
        .route_i (route),
        .data_o  (routed_vec)
    );

    pnet_capture i_capture (
        .clk     (clk),
        .rst     (rst),
        .valid_i (net_valid_i),
        .legal_i (route.legal),
        .data_i  (routed_vec),
        .data_o  (out_vec),
        .bad_o   (bad_fn_o)
    );

    assign lane0_o = out_vec[0];
    assign lane1_o = out_vec[1];
    assign lane2_o = out_vec[2];
    assign lane3_o = out_vec[3];
endmodule

// File: rtl/pnet_checker.sv
module pnet_checker (
    input logic        clk,
    input logic        rst,
    input logic        net_valid_i,
    input logic [3:0]  net_fn_i,
    input logic [15:0] lane0_i,
    input logic [15:0] lane1_i,
    input logic [15:0] lane2_i,
    input logic [15:0] lane3_i,
    input logic [15:0] lane0_o,
    input logic [15:0] lane1_o,
    input logic [15:0] lane2_o,
    input logic [15:0] lane3_o,
    input logic        bad_fn_o
);
    a_r2_rotate: assert property (@(posedge clk) disable iff (rst)
        net_valid_i && net_fn_i == 4'd0 |=>
            lane1_o == $past(lane0_i) && lane2_o == $past(lane1_i) &&
            lane3_o == $past(lane2_i) && lane0_o == $past(lane3_i));

    a_r3_mirror: assert property (@(posedge clk) disable iff (rst)
        net_valid_i && net_fn_i == 4'd1 |=>
            lane0_o == $past(lane3_i) && lane1_o == $past(lane2_i) &&
            lane2_o == $past(lane1_i) && lane3_o == $past(lane0_i));

    a_r4_inner: assert property (@(posedge clk) disable iff (rst)
        net_valid_i && net_fn_i == 4'd2 |=>
            lane0_o == $past(lane0_i) && lane1_o == $past(lane2_i) &&
            lane2_o == $past(lane1_i) && lane3_o == $past(lane3_i));

    a_r5_pair: assert property (@(posedge clk) disable iff (rst)
        net_valid_i && net_fn_i == 4'd3 |=>
            lane0_o == $past(lane1_i) && lane1_o == $past(lane0_i) &&
            lane2_o == $past(lane3_i) && lane3_o == $past(lane2_i));

    a_r6_half: assert property (@(posedge clk) disable iff (rst)
        net_valid_i && net_fn_i == 4'd4 |=>
            lane0_o == $past(lane2_i) && lane1_o == $past(lane3_i) &&
            lane2_o == $past(lane0_i) && lane3_o == $past(lane1_i));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !net_valid_i |=>
            $stable(lane0_o) && $stable(lane1_o) && $stable(lane2_o) && $stable(lane3_o));

    a_r9_illegal_hold: assert property (@(posedge clk) disable iff (rst)
        net_valid_i && net_fn_i > 4'd4 |=>
            bad_fn_o && $stable(lane0_o) && $stable(lane1_o) &&
            $stable(lane2_o) && $stable(lane3_o));

    a_r10_flag_quiet: assert property (@(posedge clk) disable iff (rst)
        !(net_valid_i && net_fn_i > 4'd4) |=> !bad_fn_o);
endmodule

bind lane_permute_net pnet_checker i_pnet_checker (
    .clk         (clk),
    .rst         (rst),
    .net_valid_i (net_valid_i),
    .net_fn_i    (net_fn_i),
    .lane0_i     (lane0_i),
    .lane1_i     (lane1_i),
    .lane2_i     (lane2_i),
    .lane3_i     (lane3_i),
    .lane0_o     (lane0_o),
    .lane1_o     (lane1_o),
    .lane2_o     (lane2_o),
    .lane3_o     (lane3_o),
    .bad_fn_o    (bad_fn_o)
);

// File: tb/test_lane_permute_net.sv
module test_lane_permute_net;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [3:0]  fn = 4'd0;
    logic [15:0] din [4];
    logic [15:0] q0, q1, q2, q3;
    logic        bad;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    lane_permute_net i_lane_permute_net (
        .clk (clk), .rst (rst), .net_valid_i (valid), .net_fn_i (fn),
        .lane0_i (din[0]), .lane1_i (din[1]), .lane2_i (din[2]), .lane3_i (din[3]),
        .lane0_o (q0), .lane1_o (q1), .lane2_o (q2), .lane3_o (q3),
        .bad_fn_o (bad)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_outs(string req, logic [15:0] e0, e1, e2, e3);
        chk(req, "lane0", q0, e0);
        chk(req, "lane1", q1, e1);
        chk(req, "lane2", q2, e2);
        chk(req, "lane3", q3, e3);
    endtask

    task automatic set_in(logic [15:0] a, b, c, d);
        din[0] = a; din[1] = b; din[2] = c; din[3] = d;
    endtask

    // Issue one strobe; returns at the negedge after the capturing edge.
    task automatic strobe(logic [3:0] code);
        @(negedge clk);
        valid = 1'b1;
        fn = code;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic t_reset;
        set_in(16'h1111, 16'h2222, 16'h3333, 16'h4444);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk_outs("R1", 16'h0, 16'h0, 16'h0, 16'h0);
        chk("R1", "flag", {15'b0, bad}, 16'h0);
        rst = 1'b0;
    endtask

    task automatic t_rotate;
        set_in(16'hA000, 16'hA001, 16'hA002, 16'hA003);
        strobe(4'b0000);
        chk_outs("R2", 16'hA003, 16'hA000, 16'hA001, 16'hA002);
        chk("R10", "flag legal", {15'b0, bad}, 16'h0);
    endtask

    task automatic t_mirror;
        set_in(16'hB010, 16'hB020, 16'hB030, 16'hB040);
        strobe(4'b0001);
        chk_outs("R3", 16'hB040, 16'hB030, 16'hB020, 16'hB010);
    endtask

    task automatic t_inner;
        set_in(16'h0C01, 16'h0C02, 16'h0C03, 16'h0C04);
        strobe(4'b0010);
        chk_outs("R4", 16'h0C01, 16'h0C03, 16'h0C02, 16'h0C04);
    endtask

    task automatic t_pair;
        set_in(16'hD00D, 16'hBEEF, 16'h1234, 16'hFFFF);
        strobe(4'b0011);
        chk_outs("R5", 16'hBEEF, 16'hD00D, 16'hFFFF, 16'h1234);
    endtask

    task automatic t_half;
        set_in(16'h0001, 16'h8000, 16'h7FFF, 16'h5A5A);
        strobe(4'b0100);
        chk_outs("R6", 16'h7FFF, 16'h5A5A, 16'h0001, 16'h8000);
    endtask

    task automatic t_latency;
        set_in(16'h1000, 16'h2000, 16'h3000, 16'h4000);
        strobe(4'b0011);
        @(negedge clk);
        valid = 1'b1;
        fn = 4'b0100;
        set_in(16'h0010, 16'h0020, 16'h0030, 16'h0040);
        #2;
        chk_outs("R7 before edge", 16'h2000, 16'h1000, 16'h4000, 16'h3000);
        @(negedge clk);
        valid = 1'b0;
        chk_outs("R7 after edge", 16'h0030, 16'h0040, 16'h0010, 16'h0020);
    endtask

    task automatic t_idle_hold;
        set_in(16'h5555, 16'h6666, 16'h7777, 16'h8888);
        strobe(4'b0000);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            fn = 4'(k);
            set_in(16'(k * 16'h0101), 16'hFFFF, 16'(k), 16'h0F0F);
        end
        @(negedge clk);
        chk_outs("R8", 16'h8888, 16'h5555, 16'h6666, 16'h7777);
        chk("R10", "flag idle", {15'b0, bad}, 16'h0);
    endtask

    task automatic t_illegal;
        set_in(16'hC0DE, 16'hCAFE, 16'hF00D, 16'hFACE);
        strobe(4'b0001);
        for (int c = 5; c < 16; c++) begin
            set_in(16'(c), 16'(c + 16), 16'(c + 32), 16'(c + 48));
            strobe(4'(c));
            chk_outs("R9", 16'hFACE, 16'hF00D, 16'hCAFE, 16'hC0DE);
            chk("R9", "flag raised", {15'b0, bad}, 16'h1);
            @(negedge clk);
            chk("R10", "flag dropped", {15'b0, bad}, 16'h0);
        end
    endtask

    initial begin
        set_in(16'h0, 16'h0, 16'h0, 16'h0);
        t_reset();
        t_rotate();
        t_mirror();
        t_inner();
        t_pair();
        t_half();
        t_latency();
        t_idle_hold();
        t_illegal();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule